// File: doc/BRIEF.md
# Four-Channel Reload PWM Timer

This block is a free-running up-counter that drives four pulse-width-modulated outputs sharing one frequency. The counter does not count from zero to a programmable top. It counts from a programmable start value up to the all-ones value of its width and then reloads the start value, so the period is `2^CNT_W - start` counter ticks. The counter advances only on cycles where the count enable input is high. This lets a clock divider outside the block set the tick rate.

Each channel has a compare value. Every output is driven high at the overflow. It is driven low once the count reaches that channel's compare value. Software writes compare values into shadow copies, and these copies move into the active compare registers only at an overflow, so a period is never cut or stretched halfway through. Each output also has an inversion bit. A global commit-mode bit chooses whether inversion changes wait for the overflow or apply at once. Inversion also gives exact 0% and 100% duty.

Top module: `pwm4_reload_timer`

## Requirements
- R1: With count enable high on every cycle, the counter steps by one per cycle from the start value up to 4095. The step after 4095 loads the start value, so overflows are `4096 - start` cycles apart. Out of reset the count is 0 and the start value is 0, so the first overflow comes after 4096 enabled cycles.
- R2: While reset is high, and after it until the first overflow (with inversion bits at their reset value 0), every output is low and `ovf_pulse` is low.
- R3: On a cycle with `cnt_en` low, the counter does not move, and neither the outputs nor `ovf_pulse` change.
- R4: `ovf_pulse` is high for exactly one cycle: the cycle after the clock edge at which the counter reloads. In that same cycle every non-inverted output is high, and the shadow compare values have become active.
- R5: A non-inverted output goes low in the first cycle in which the count equals its active compare value. Its high time per period is therefore `compare - start` cycles.
- R6: If a channel's compare value is less than or equal to the start value, its non-inverted output stays high for the whole period.
- R7: A compare-value write has no effect on the period in progress. It takes effect from the next overflow on.
- R8: With the commit-mode bit set (its reset value), an inversion-bit write leaves the outputs unchanged until the next overflow, and from then on the output is inverted.
- R9: With the commit-mode bit clear, an inversion write made in the cycle with the write strobe shows at the outputs two samples later (the register write at the next edge, then the output register). No overflow is needed.
- R10: Inverting a channel whose compare value is at or below the start value gives an output that is low for the whole period (0% duty).
- R11: Write map. A write happens when `wr_en` is high at a clock edge. Address 0 is the start value. Addresses 1 to 4 are the compare values of channels 0 to 3. At address 5, `wr_data[i]` is the inversion bit of channel i. At address 6, `wr_data[0]` is the commit-mode bit. Writes to any other address change nothing.
- R12: With start 4094 and compare 4095, the period is 2 cycles and the output is high for 1 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 12 | Register write data |
| pwm_out | output | 4 | PWM outputs, bit i is channel i |
| ovf_pulse | output | 1 | One-cycle pulse after each counter reload |

## Verification
The bench measures the high time of each channel and the distance between overflows.

- **Double buffering.** It writes a compare value and an inversion bit partway through a period. A design that loads these at once would change that period's high count instead of the next one.
- **Compare at or below the start value.** These channels must stay high all period, and inverted they must stay low all period. A design that compares against the raw count, or that lets the wrap lose to a match, would produce short pulses here.
- **Immediate commit mode.** The bench checks the exact sample at which inversion appears, which catches an extra or a missing pipeline stage.
- **Paused count and tightest period.** A paused count must stretch the period by exactly the pause. The tightest configuration must give a period of 2, which exposes off-by-one errors in the reload.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  // Register write address map (inversion and commit-mode follow the duty block)
  localparam int unsigned ADR_RELOAD    = 0;
  localparam int unsigned ADR_DUTY_BASE = 1;

  function automatic int unsigned adr_pol(input int unsigned nch);
    return ADR_DUTY_BASE + nch;
  endfunction

  function automatic int unsigned adr_mode(input int unsigned nch);
    return ADR_DUTY_BASE + nch + 1;
  endfunction
endpackage

// File: rtl/pwm4_counter.sv
module pwm4_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign wrap    = cnt_en && (cnt_q == CNT_MAX);
  assign cnt_nxt = (cnt_q == CNT_MAX) ? reload : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (cnt_en) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  output logic [CNT_W-1:0]          reload_q,
  output logic [NCH-1:0][CNT_W-1:0] pre_q,
  output logic [NCH-1:0]            pol_pre_q,
  output logic                      mode_q
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(ADR_RELOAD);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(adr_pol(NCH));
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(adr_mode(NCH));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q  <= '0;
      pol_pre_q <= '0;
      mode_q    <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == A_RELOAD) reload_q  <= wr_data;
      if (wr_addr == A_POL)    pol_pre_q <= wr_data[NCH-1:0];
      if (wr_addr == A_MODE)   mode_q    <= wr_data[0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_duty
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADR_DUTY_BASE + g);
    always_ff @(posedge clk) begin
      if (rst)                             pre_q[g] <= '0;
      else if (wr_en && wr_addr == A_DUTY) pre_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] pre,
  input  logic             pol_pre,
  input  logic             mode,
  output logic [CNT_W-1:0] cmp_q,
  output logic             raw_q,
  output logic             pol_q,
  output logic             pwm_q
);
  logic raw_d;
  logic pol_d;

  always_comb begin
    raw_d = raw_q;
    if (wrap)                              raw_d = 1'b1;
    else if (cnt_en && (cnt_nxt == cmp_q)) raw_d = 1'b0;
  end

  always_comb begin
    pol_d = pol_q;
    if (!mode || wrap) pol_d = pol_pre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      raw_q <= 1'b0;
      pol_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      if (wrap) cmp_q <= pre;
      raw_q <= raw_d;
      pol_q <= pol_d;
      pwm_q <= raw_d ^ pol_d;
    end
  end
endmodule

// File: rtl/pwm4_reload_timer.sv
module pwm4_reload_timer #(
  parameter int CNT_W  = 12,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NCH-1:0]    pwm_out,
  output logic              ovf_pulse
);
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W-1:0]          cnt_nxt;
  logic                      wrap;
  logic [CNT_W-1:0]          reload_q;
  logic [NCH-1:0][CNT_W-1:0] pre_all;
  logic [NCH-1:0][CNT_W-1:0] cmp_all;
  logic [NCH-1:0]            pol_pre;
  logic [NCH-1:0]            pol_act;
  logic [NCH-1:0]            raw_all;
  logic                      mode_q;

  pwm4_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .reload(reload_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap), .ovf_q(ovf_pulse)
  );

  pwm4_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_q(reload_q), .pre_q(pre_all), .pol_pre_q(pol_pre), .mode_q(mode_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm4_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .wrap(wrap), .cnt_nxt(cnt_nxt),
      .pre(pre_all[g]), .pol_pre(pol_pre[g]), .mode(mode_q),
      .cmp_q(cmp_all[g]), .raw_q(raw_all[g]), .pol_q(pol_act[g]),
      .pwm_q(pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm4_reload_chk.sv
module pwm4_reload_chk #(
  parameter int CNT_W = 12,
  parameter int NCH   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cnt_en,
  input logic                 ovf_pulse,
  input logic                 mode_q,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [CNT_W-1:0]     reload_q,
  input logic [NCH*CNT_W-1:0] pre_flat,
  input logic [NCH*CNT_W-1:0] cmp_flat,
  input logic [NCH-1:0]       raw_all,
  input logic [NCH-1:0]       pol_pre,
  input logic [NCH-1:0]       pol_act
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic at_top;
  assign at_top = cnt_en && (cnt_q == TOP);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    at_top |=> cnt_q == $past(reload_q)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    at_top |=> ovf_pulse && (&raw_all) && cmp_flat == $past(pre_flat)); // R4
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !at_top |=> !ovf_pulse); // R4
  AST_CMP_KEEP: assert property (@(posedge clk) disable iff (rst)
    !at_top |=> $stable(cmp_flat)); // R7
  AST_POL_DEFER: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !at_top) |=> $stable(pol_act)); // R8
  AST_POL_NOW: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> pol_act == $past(pol_pre)); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_match
    AST_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && cnt_q != TOP && (cnt_q + 1'b1) == cmp_flat[g*CNT_W +: CNT_W])
      |=> !raw_all[g]); // R5
  end
endmodule

bind pwm4_reload_timer pwm4_reload_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .ovf_pulse(ovf_pulse),
  .mode_q(mode_q), .cnt_q(cnt_q), .reload_q(reload_q),
  .pre_flat(pre_all), .cmp_flat(cmp_all), .raw_all(raw_all),
  .pol_pre(pol_pre), .pol_act(pol_act)
);

// File: tb/sim_pwm4_reload_timer.sv
`timescale 1ns/1ps
module sim_pwm4_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  pwm_out;
  logic        ovf_pulse;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm4_reload_timer u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ovf();
    do @(negedge clk); while (!ovf_pulse);
  endtask

  // Starts on a sample with ovf_pulse high; returns on the next such sample.
  task automatic measure(input int wk, input logic [3:0] wa, input logic [11:0] wd,
                         output int per, output int hi[4]);
    per = 0;
    hi = '{default: 0};
    do begin
      for (int c = 0; c < 4; c++) if (pwm_out[c]) hi[c]++;
      if (per == wk) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      else wr_en = 1'b0;
      per++;
      @(negedge clk);
    end while (!ovf_pulse);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_and_first();
    int n = 0;
    int bad = 0;
    repeat (3) @(negedge clk);
    chk("R2 pwm in reset", int'(pwm_out), 0);
    chk("R2 ovf in reset", int'(ovf_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    wr(4'd0, 12'd4000);
    wr(4'd1, 12'd4010);
    wr(4'd2, 12'd4095);
    wr(4'd3, 12'd4000);
    wr(4'd4, 12'd3000);
    chk("R3 outputs idle with cnt_en low", int'(pwm_out), 0);
    cnt_en = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (!ovf_pulse && pwm_out != 4'b0) bad++;
    end while (!ovf_pulse && n < 5000);
    chk("R1 first overflow after 4096 ticks from 0", n, 4096);
    chk("R2 outputs low before first overflow", bad, 0);
    chk("R4 all outputs high at overflow", int'(pwm_out), 15);
  endtask

  task automatic t_duty();
    int per;
    int hi[4];
    measure(-1, 4'd0, 12'd0, per, hi);
    chk("R1 period 4096-4000", per, 96);
    chk("R4 ovf single cycle (period>1)", int'(per > 1), 1);
    chk("R5 ch0 high time 4010-4000", hi[0], 10);
    chk("R5 ch1 high time 4095-4000", hi[1], 95);
    chk("R6 ch2 compare equal start stays high", hi[2], 96);
    chk("R6 ch3 compare below start stays high", hi[3], 96);
  endtask

  task automatic t_preload();
    int per;
    int hi[4];
    measure(20, 4'd1, 12'd4050, per, hi);
    chk("R7 ch0 current period unchanged", hi[0], 10);
    measure(-1, 4'd0, 12'd0, per, hi);
    chk("R7 ch0 new compare after overflow", hi[0], 50);
  endtask

  task automatic t_pol_sync();
    int per;
    int hi[4];
    measure(5, 4'd5, 12'b0101, per, hi);
    chk("R8 ch0 inversion deferred", hi[0], 50);
    chk("R8 ch2 inversion deferred", hi[2], 96);
    measure(-1, 4'd0, 12'd0, per, hi);
    chk("R8 ch0 inverted after overflow", hi[0], 46);
    chk("R10 ch2 inverted gives 0% duty", hi[2], 0);
    chk("R8 ch3 not inverted", hi[3], 96);
  endtask

  task automatic t_hold();
    int n = 0;
    int bad = 0;
    logic [3:0] snap;
    repeat (10) begin @(negedge clk); n++; end
    snap = pwm_out;
    cnt_en = 1'b0;
    repeat (50) begin
      @(negedge clk);
      n++;
      if (pwm_out != snap || ovf_pulse) bad++;
    end
    cnt_en = 1'b1;
    do begin @(negedge clk); n++; end while (!ovf_pulse && n < 1000);
    chk("R3 outputs frozen while paused", bad, 0);
    chk("R3 period stretched by pause", n, 146);
  endtask

  task automatic t_unmapped();
    int per;
    int hi[4];
    measure(3, 4'd15, 12'd0, per, hi);
    measure(-1, 4'd0, 12'd0, per, hi);
    chk("R11 unmapped write keeps period", per, 96);
    chk("R11 unmapped write keeps ch0", hi[0], 46);
    chk("R11 unmapped write keeps ch1", hi[1], 95);
    chk("R11 unmapped write keeps ch3", hi[3], 96);
  endtask

  task automatic t_pol_now();
    int per;
    int hi[4];
    wr(4'd6, 12'd0);
    wr(4'd5, 12'b1101);
    chk("R9 ch3 unchanged one sample after write", int'(pwm_out[3]), 1);
    @(negedge clk);
    chk("R9 ch3 inverted two samples after write", int'(pwm_out[3]), 0);
    chk("R9 no overflow needed", int'(ovf_pulse), 0);
    wait_ovf();
    measure(-1, 4'd0, 12'd0, per, hi);
    chk("R10 ch3 inverted gives 0% duty", hi[3], 0);
    chk("R9 ch1 still not inverted", hi[1], 95);
  endtask

  task automatic t_tight();
    int per;
    int hi[4];
    wr(4'd0, 12'd4094);
    wr(4'd1, 12'd4095);
    wr(4'd5, 12'b0000);
    wait_ovf();
    measure(-1, 4'd0, 12'd0, per, hi);
    chk("R12 period with start 4094", per, 2);
    chk("R12 ch0 high 1 of 2", hi[0], 1);
    chk("R12 ch1 high 1 of 2", hi[1], 1);
    chk("R6 ch2 below start high all period", hi[2], 2);
  endtask

  initial begin
    t_reset_and_first();
    t_duty();
    t_preload();
    t_pol_sync();
    t_hold();
    t_unmapped();
    t_pol_now();
    t_tight();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule